// File: doc/BRIEF.md
# Infrared Pulse Encoder for Serial Transmit Data

This block turns the transmit bit stream of a UART into the return-to-zero light pulses used by serial infrared links. It runs on the system clock and advances on a one-cycle enable, `bit_tick`, that arrives sixteen times per bit. Each bit period is split into sixteen slots. A zero bit gives a short high pulse in slots 7 to 9. A one bit leaves the output dark for the whole period.

The slot counter is not free-running. It waits idle until a tick sees the line low, which is the start bit of a frame. That tick becomes slot 0 of the first period. The counter then steps through whole periods and reads the line only at each slot 0. After a run of high bits it falls back to idle, so the next start bit sets the alignment again.

The pulse passes through a width limiter before the output register. The limiter counts system clocks, so it bounds the light-on time even when the tick rate is low. An asynchronous active-low reset forces the output dark and returns the encoder to idle.

Top module: `irtx_pulse_encoder`

## Requirements
- R1: One bit period is `CYC_PER_BIT` (16) ticks, numbered slot 0 to slot 15. The line is read only on the slot-0 tick. A change of `tx_bit` on any other tick of an active period has no effect on the output.
- R2: For a zero bit, the output is low for slots 0 to 6, high for slots 7, 8 and 9, and low for slots 10 to 15. Because of the two register stages, `ir_out` rises one clock after the edge that samples the slot-7 tick. It falls one clock after the edge that samples the slot-10 tick.
- R3: For a one bit, `ir_out` stays low for the whole period.
- R4: While idle, a tick with `tx_bit` high leaves the encoder idle. A tick with `tx_bit` low starts a period, and that tick is slot 0 of it.
- R5: When a slot-0 tick reads the line high, and the `IDLE_BITS-1` bits read before it were also high, the encoder returns to idle. Fewer consecutive high bits keep it active.
- R6: `ir_out` is never high for more than `MAX_HIGH_CLKS` consecutive clocks. A clipped pulse stays low for the rest of its length. A pulse of at most `MAX_HIGH_CLKS` clocks passes with its full width.
- R7: While `rst_n` is low, `ir_out` is low at once, without waiting for a clock edge. After release, the encoder is idle and the output stays low until a pulse is encoded.
- R8: State moves only on clocks with `bit_tick` high. An unclipped pulse therefore lasts three times the tick spacing, in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces the output low |
| bit_tick | input | 1 | One-cycle enable at sixteen times the baud rate |
| tx_bit | input | 1 | UART transmit line (1 = idle/mark) |
| ir_out | output | 1 | Registered drive level for the infrared emitter |

## Verification
The bench sweeps the tick spacing from one to five clocks against a limit of nine clocks. The spacing of three gives a pulse of exactly the limit, and the spacings of four and five give pulses that must be clipped. A limiter that is off by one or cuts pulses it should pass then shows up as a wrong high count. Every clock of every period is compared, so a pulse one slot early or late, or a missing register stage, is reported in the cycle where it happens. The bench also changes the line in the middle of a high bit, just before the run of high bits is long enough to end the frame. An encoder that goes idle too early, or that reads the line at slots other than 0, then puts a pulse out of alignment. Finally, idle ticks at an odd offset before a start bit show whether the counter realigns, and a reset in the middle of a pulse must darken the output without a clock edge.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  // Slot index that follows `slot`, wrapping after `last_slot`.
  function automatic int unsigned slot_after(input int unsigned slot,
                                             input int unsigned last_slot);
    return (slot == last_slot) ? 0 : slot + 1;
  endfunction

  // Whether a slot of a bit period carries light, given the bit value.
  function automatic logic slot_lit(input int unsigned slot,
                                    input logic        data_bit,
                                    input int unsigned first_lit,
                                    input int unsigned lit_count);
    return (data_bit == 1'b0) && (slot >= first_lit) &&
           (slot < first_lit + lit_count);
  endfunction

  // Next value of a saturating run counter.
  function automatic int unsigned run_step(input int unsigned run,
                                           input int unsigned ceiling);
    return (run >= ceiling) ? ceiling : run + 1;
  endfunction

endpackage

// File: rtl/irtx_phase_ctrl.sv
module irtx_phase_ctrl #(
  parameter int CYC_PER_BIT = 16,
  parameter int IDLE_BITS   = 10,
  parameter int PHASE_W     = $clog2(CYC_PER_BIT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               tx_bit,
  output logic               slot_valid,
  output logic [PHASE_W-1:0] slot,
  output logic               slot_bit,
  output logic               active,
  output logic               frame_start,
  output logic               idle_enter
);
  import irtx_pkg::*;

  localparam int ONES_W = (IDLE_BITS < 2) ? 1 : $clog2(IDLE_BITS);
  localparam logic [PHASE_W-1:0] LAST_SLOT  = PHASE_W'(CYC_PER_BIT - 1);
  localparam logic [PHASE_W-1:0] FIRST_STEP = PHASE_W'(1);
  localparam logic [ONES_W-1:0]  ONES_LIMIT = ONES_W'(IDLE_BITS - 1);

  logic               active_q;
  logic [PHASE_W-1:0] next_slot_q;
  logic               bit_q;
  logic [ONES_W-1:0]  ones_q;
  logic               at_boundary;
  logic [PHASE_W-1:0] slot_inc;

  assign frame_start = bit_tick & ~active_q & ~tx_bit;
  assign at_boundary = bit_tick & active_q & (next_slot_q == '0);
  assign slot_valid  = frame_start | (bit_tick & active_q);
  assign slot        = active_q ? next_slot_q : '0;
  assign slot_bit    = (frame_start | at_boundary) ? tx_bit : bit_q;
  assign idle_enter  = at_boundary & tx_bit & (ones_q == ONES_LIMIT);
  assign active      = active_q;
  assign slot_inc    = PHASE_W'(slot_after(int'(next_slot_q), int'(LAST_SLOT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      next_slot_q <= '0;
      bit_q       <= 1'b1;
      ones_q      <= '0;
    end else if (frame_start) begin
      active_q    <= 1'b1;
      next_slot_q <= FIRST_STEP;
      bit_q       <= 1'b0;
      ones_q      <= '0;
    end else if (at_boundary) begin
      bit_q <= tx_bit;
      if (idle_enter) begin
        active_q    <= 1'b0;
        next_slot_q <= '0;
        ones_q      <= '0;
      end else begin
        next_slot_q <= FIRST_STEP;
        ones_q      <= tx_bit ? ones_q + 1'b1 : '0;
      end
    end else if (bit_tick && active_q) begin
      next_slot_q <= slot_inc;
    end
  end

endmodule

// File: rtl/irtx_shaper.sv
module irtx_shaper #(
  parameter int CYC_PER_BIT = 16,
  parameter int PULSE_SLOT  = 7,
  parameter int PULSE_SLOTS = 3,
  parameter int PHASE_W     = $clog2(CYC_PER_BIT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_valid,
  input  logic [PHASE_W-1:0] slot,
  input  logic               slot_bit,
  output logic               pulse_q,
  output logic               pulse_rise
);
  import irtx_pkg::*;

  logic lit_now;

  assign lit_now    = slot_lit(int'(slot), slot_bit, PULSE_SLOT, PULSE_SLOTS);
  assign pulse_rise = slot_valid & lit_now & ~pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else if (slot_valid) begin
      pulse_q <= lit_now;
    end
  end

endmodule

// File: rtl/irtx_width_limiter.sv
module irtx_width_limiter #(
  parameter int MAX_HIGH_CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic out_q,
  output logic clip_event
);
  import irtx_pkg::*;

  localparam int HC_W = $clog2(MAX_HIGH_CLKS + 1);
  localparam logic [HC_W-1:0] HC_MAX = HC_W'(MAX_HIGH_CLKS);

  logic [HC_W-1:0] high_cnt_q;
  logic            clipped_q;
  logic            at_limit;

  assign at_limit   = out_q & (high_cnt_q == HC_MAX);
  assign clip_event = pulse_in & ~clipped_q & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q      <= 1'b0;
      high_cnt_q <= '0;
      clipped_q  <= 1'b0;
    end else if (!pulse_in) begin
      out_q      <= 1'b0;
      high_cnt_q <= '0;
      clipped_q  <= 1'b0;
    end else if (clipped_q) begin
      out_q <= 1'b0;
    end else if (at_limit) begin
      out_q     <= 1'b0;
      clipped_q <= 1'b1;
    end else begin
      out_q      <= 1'b1;
      high_cnt_q <= HC_W'(run_step(int'(high_cnt_q), MAX_HIGH_CLKS));
    end
  end

endmodule

// File: rtl/irtx_pulse_encoder.sv
module irtx_pulse_encoder #(
  parameter int CYC_PER_BIT   = 16,
  parameter int PULSE_SLOT    = 7,
  parameter int PULSE_SLOTS   = 3,
  parameter int MAX_HIGH_CLKS = 1000,
  parameter int IDLE_BITS     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_bit,
  output logic ir_out
);
  localparam int PHASE_W = $clog2(CYC_PER_BIT);

  logic               ctl_slot_valid;
  logic [PHASE_W-1:0] ctl_slot;
  logic               ctl_slot_bit;
  logic               ctl_active;
  logic               ctl_frame_start;
  logic               ctl_idle_enter;
  logic               shp_pulse_q;
  logic               shp_pulse_rise;
  logic               lim_clip_event;

  irtx_phase_ctrl #(
    .CYC_PER_BIT(CYC_PER_BIT),
    .IDLE_BITS  (IDLE_BITS),
    .PHASE_W    (PHASE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_bit     (tx_bit),
    .slot_valid (ctl_slot_valid),
    .slot       (ctl_slot),
    .slot_bit   (ctl_slot_bit),
    .active     (ctl_active),
    .frame_start(ctl_frame_start),
    .idle_enter (ctl_idle_enter)
  );

  irtx_shaper #(
    .CYC_PER_BIT(CYC_PER_BIT),
    .PULSE_SLOT (PULSE_SLOT),
    .PULSE_SLOTS(PULSE_SLOTS),
    .PHASE_W    (PHASE_W)
  ) u_shaper (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_valid(ctl_slot_valid),
    .slot      (ctl_slot),
    .slot_bit  (ctl_slot_bit),
    .pulse_q   (shp_pulse_q),
    .pulse_rise(shp_pulse_rise)
  );

  irtx_width_limiter #(
    .MAX_HIGH_CLKS(MAX_HIGH_CLKS)
  ) u_limiter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_in  (shp_pulse_q),
    .out_q     (ir_out),
    .clip_event(lim_clip_event)
  );

endmodule

// File: rtl/irtx_pulse_encoder_chk.sv
module irtx_pulse_encoder_chk #(
  parameter int CYC_PER_BIT   = 16,
  parameter int PULSE_SLOT    = 7,
  parameter int MAX_HIGH_CLKS = 1000,
  parameter int PHASE_W       = $clog2(CYC_PER_BIT)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_tick,
  input logic               tx_bit,
  input logic               ir_out,
  input logic               slot_valid,
  input logic [PHASE_W-1:0] slot,
  input logic               slot_bit,
  input logic               active,
  input logic               pulse_q
);
  localparam int RUN_W = $clog2(MAX_HIGH_CLKS + 2);

  logic [RUN_W-1:0]   run_q;
  logic [PHASE_W-1:0] last_slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      last_slot_q <= '0;
    end else begin
      run_q <= ir_out ? ((run_q > RUN_W'(MAX_HIGH_CLKS)) ? run_q : run_q + 1'b1) : '0;
      if (slot_valid) last_slot_q <= slot;
    end
  end

  assert_slot_sequence_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot != '0) |-> (slot == PHASE_W'(last_slot_q + 1'b1)));

  assert_zero_lights_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_bit && slot == PHASE_W'(PULSE_SLOT)) |=> pulse_q);

  assert_one_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_bit) |=> !pulse_q);

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && bit_tick && tx_bit) |=> !active);

  assert_high_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ir_out |-> (run_q < RUN_W'(MAX_HIGH_CLKS)));

  assert_rise_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_out) |-> $past(pulse_q));

  assert_tick_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(pulse_q));

endmodule

bind irtx_pulse_encoder irtx_pulse_encoder_chk #(
  .CYC_PER_BIT  (CYC_PER_BIT),
  .PULSE_SLOT   (PULSE_SLOT),
  .MAX_HIGH_CLKS(MAX_HIGH_CLKS),
  .PHASE_W      (PHASE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .tx_bit    (tx_bit),
  .ir_out    (ir_out),
  .slot_valid(ctl_slot_valid),
  .slot      (ctl_slot),
  .slot_bit  (ctl_slot_bit),
  .active    (ctl_active),
  .pulse_q   (shp_pulse_q)
);

// File: tb/irtx_pulse_encoder_tb.sv
module irtx_pulse_encoder_tb;
  localparam int SLOTS   = 16;
  localparam int LIT_AT  = 7;
  localparam int LIT_END = 10;
  localparam int MAXH    = 9;
  localparam int IDLEB   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic tx_bit = 1'b1;
  logic ir_out;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  irtx_pulse_encoder #(
    .CYC_PER_BIT(SLOTS), .PULSE_SLOT(LIT_AT), .PULSE_SLOTS(LIT_END - LIT_AT),
    .MAX_HIGH_CLKS(MAXH), .IDLE_BITS(IDLEB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_bit(tx_bit), .ir_out(ir_out)
  );

  always #2 clk = ~clk;

  function automatic logic expect_lit(input logic b, input int sp, input int k);
    int lo;
    int hi;
    if (b) return 1'b0;
    lo = LIT_AT * sp + 1;
    hi = LIT_END * sp;
    if (hi - LIT_AT * sp > MAXH) hi = LIT_AT * sp + MAXH;
    return (k >= lo) && (k <= hi);
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input int k);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s clk=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  // One bit period; tx flips to !b from slot `flip` onward (flip<0: never).
  task automatic run_period(input logic b, input int sp, input int flip, input string req);
    for (int k = 0; k < SLOTS * sp; k++) begin
      bit_tick = (k % sp == 0);
      if (k == 0) tx_bit = b;
      if (flip >= 0 && k == flip * sp) tx_bit = ~b;
      @(posedge clk);
      @(negedge clk);
      check(ir_out, expect_lit(b, sp, k), req, k);
    end
    bit_tick = 1'b0;
  endtask

  task automatic idle_ticks(input int n, input int sp);
    tx_bit = 1'b1;
    for (int k = 0; k < n * sp; k++) begin
      bit_tick = (k % sp == 0);
      @(posedge clk);
      @(negedge clk);
      check(ir_out, 1'b0, "R4 idle", k);
    end
    bit_tick = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] data, input int sp);
    run_period(1'b0, sp, -1, "R2 start");
    for (int i = 0; i < 8; i++)
      run_period(data[i], sp, -1, data[i] ? "R3 one" : "R2/R6/R8 zero");
    for (int i = 0; i < IDLEB; i++) run_period(1'b1, sp, -1, "R5 stop");
  endtask

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hA5; pats[2] = 8'hFF; pats[3] = 8'h1E;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(ir_out, 1'b0, "R7 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ir_out, 1'b0, "R7 after release", 0);

    // Sweep tick spacing; spacing 3 hits the limit exactly, 4 and 5 are clipped (R6, R8).
    for (int sp = 1; sp <= 5; sp++) begin
      for (int p = 0; p < 4; p++) begin
        idle_ticks(5, sp);  // odd offset before the start bit (R4)
        send_frame(pats[p], sp);
      end
    end

    // R1/R5: mid-period change while one high bit short of idling is ignored.
    for (int sp = 1; sp <= 2; sp++) begin
      idle_ticks(3, sp);
      run_period(1'b0, sp, -1, "R1 start");
      for (int i = 0; i < IDLEB - 2; i++) run_period(1'b1, sp, -1, "R5 run");
      run_period(1'b1, sp, 3, "R1 mid-period change");
      run_period(1'b0, sp, -1, "R5 still aligned");
      for (int i = 0; i < IDLEB; i++) run_period(1'b1, sp, -1, "R5 stop");
    end

    // R5: after idling, odd-offset ticks then a start bit realign the period.
    idle_ticks(7, 2);
    run_period(1'b0, 2, -1, "R5 realign");
    for (int i = 0; i < IDLEB; i++) run_period(1'b1, 2, -1, "R5 stop");

    // R7: reset in the middle of a lit pulse darkens the output at once.
    tx_bit = 1'b0;
    for (int k = 0; k <= LIT_AT * 2 + 2; k++) begin
      bit_tick = (k % 2 == 0);
      @(posedge clk);
      @(negedge clk);
      check(ir_out, expect_lit(1'b0, 2, k), "R7 pre-reset", k);
    end
    bit_tick = 1'b0;
    rst_n = 1'b0;
    #1;
    check(ir_out, 1'b0, "R7 async clear", 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ir_out, 1'b0, "R7 dark after release", 0);
    idle_ticks(3, 2);
    run_period(1'b0, 2, -1, "R7 idle after reset");
    run_period(1'b1, 2, -1, "R3 one");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule